// File: doc/BRIEF.md
# DRAM CBR Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM refreshed by issuing CAS-before-RAS (CBR) cycles, so the memory's internal row counter chooses the row and no row address is needed. After reset it waits out a power-up pause. It then requests the strobe lines from the access arbiter and runs a fixed number of initialization refresh cycles. Only after the last of these cycles ends does it raise a done flag, which the arbiter uses to release normal accesses.

From then on a free-running interval timer marks one refresh as due each period. The period is the retention time divided by the row count. Refreshes that are due but have not been granted are counted, up to a ceiling. While the grant stays high, they are serviced one after another. Every timing value is a parameter given in nanoseconds, microseconds or milliseconds and is converted to clock cycles by package functions, with the clock rate given in kHz.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, ras_n, cas_n and we_n are 1, and ref_req and init_done are 0.
- R2: After reset is released, ref_req stays 0 and the strobes stay idle for at least PAUSE cycles, where PAUSE = ceil(CLK_KHZ*PAUSE_US/1000). ref_req rises no later than two cycles after that.
- R3: Exactly INIT_CYCLES refresh cycles (8 by default) run after the pause. init_done rises only after the RAS of the last of them has returned high, and it then stays 1 until reset.
- R4: A refresh cycle starts only if ref_gnt is 1 in an idle cycle. With ref_gnt at 0, ras_n and cas_n stay at 1. A cycle that has started always runs to its end.
- R5: In each refresh cycle, cas_n goes low at least ceil(T_CSR_NS) cycles before ras_n falls. It stays low for the whole time ras_n is low and returns high together with ras_n.
- R6: ras_n stays low for exactly ceil(T_RAS_NS) cycles. Between two cycles it stays high for at least ceil(T_RP_NS) cycles.
- R7: we_n is 1 at all times, so no refresh cycle can be taken as a write-before-RAS test-mode entry.
- R8: After init_done, one refresh becomes due every INTERVAL = floor(CLK_KHZ*RET_MS/ROWS) cycles. With ref_gnt held at 1, consecutive ras_n falling edges are exactly INTERVAL cycles apart.
- R9: Due refreshes are counted while no grant is given. ref_req is 1 whenever the count is nonzero. On grant, the counted cycles run back to back, 1+CSR+RAS+RP cycles apart, and ref_req returns to 0 once the count reaches zero.
- R10: The backlog count saturates at PEND_MAX (8 by default). Intervals that expire beyond that are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Arbiter grant of the strobe lines |
| ref_req | output | 1 | A refresh (or init cycle) is pending |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Initialization cycles completed |

## Verification
The bench builds the block for a 50 MHz clock with a 2 µs pause and 256 rows over 1 ms. This gives a pause of 100 cycles and a refresh interval of 195 cycles. These values let a run cover the whole power-up sequence, several interval periods, and a backlog that reaches its ceiling, all within a few thousand cycles. The strobe timings of 5/60/40 ns work out to 1/3/2 cycles. At these values the rounding of the setup time up to one whole cycle is in play, and each back-to-back cycle is a short, exactly known 7-cycle period.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_CSET, ST_RLOW, ST_PRE} cbr_state_t;

  // nanoseconds to clock cycles, rounded up, at least one
  function automatic int ns_to_cycles(int ns, int clk_khz);
    int c;
    c = (ns * clk_khz + 999999) / 1000000;
    return (c < 1) ? 1 : c;
  endfunction

  // microseconds to clock cycles, rounded up, at least one
  function automatic int us_to_cycles(int us, int clk_khz);
    int c;
    c = (us * clk_khz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  // spacing of refreshes: retention window split over all rows, rounded down
  function automatic int refresh_spacing(int ret_ms, int clk_khz, int rows);
    int c;
    c = (ret_ms * clk_khz) / rows;
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/dram_ref_pace.sv
module dram_ref_pace #(
  parameter int PAUSE_CYC = 10000,
  parameter int INT_CYC   = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic pause_done,
  output logic pause_fire,
  output logic tick
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INT_CYC + 1);

  logic [PW-1:0] p_cnt;
  logic [IW-1:0] i_cnt;

  assign pause_fire = !pause_done && (p_cnt == PW'(PAUSE_CYC - 1));
  assign tick       = run_en && (i_cnt == IW'(INT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_cnt      <= '0;
      pause_done <= 1'b0;
    end else if (!pause_done) begin
      p_cnt <= p_cnt + 1'b1;
      if (pause_fire) pause_done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en || tick) i_cnt <= '0;
    else                           i_cnt <= i_cnt + 1'b1;
  end

  // R2
  pause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |=> pause_done);

  // R8
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/dram_ref_pend.sv
module dram_ref_pend #(
  parameter int INIT_N = 8,
  parameter int MAX_N  = 8,
  localparam int TOP_N = (INIT_N > MAX_N) ? INIT_N : MAX_N,
  localparam int W     = $clog2(TOP_N + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         due,
  input  logic         take,
  output logic         has_work,
  output logic [W-1:0] cnt
);
  logic grow, shrink;

  assign grow     = due && !take && (cnt < W'(MAX_N));
  assign shrink   = take && !due;
  assign has_work = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= W'(INIT_N);
    else if (grow)   cnt <= cnt + 1'b1;
    else if (shrink) cnt <= cnt - 1'b1;
  end

  // R10
  pend_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |-> cnt <= W'(TOP_N));

  // R9
  take_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> has_work);

endmodule

// File: rtl/dram_ref_wave.sv
module dram_ref_wave
  import dram_ref_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int RAS_CYC = 3,
  parameter int RP_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic has_work,
  input  logic gnt,
  output logic cyc_start,
  output logic cyc_end,
  output logic ras_n,
  output logic cas_n
);
  localparam int M1 = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int MX = (M1 > RP_CYC) ? M1 : RP_CYC;
  localparam int CW = $clog2(MX + 1);

  cbr_state_t st, st_nx;
  logic [CW-1:0] cnt;
  logic          last;

  always_comb begin
    unique case (st)
      ST_CSET: last = (cnt == CW'(CSR_CYC - 1));
      ST_RLOW: last = (cnt == CW'(RAS_CYC - 1));
      ST_PRE:  last = (cnt == CW'(RP_CYC - 1));
      default: last = 1'b0;
    endcase
  end

  assign cyc_start = (st == ST_IDLE) && has_work && gnt;
  assign cyc_end   = (st == ST_PRE) && last;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (cyc_start) st_nx = ST_CSET;
      ST_CSET: if (last)      st_nx = ST_RLOW;
      ST_RLOW: if (last)      st_nx = ST_PRE;
      ST_PRE:  if (last)      st_nx = ST_IDLE;
      default:                st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= (st_nx != st) ? '0 : cnt + 1'b1;
    end
  end

  assign cas_n = !((st == ST_CSET) || (st == ST_RLOW));
  assign ras_n = (st != ST_RLOW);

  // R5
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R5
  cas_rises_with_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int CLK_KHZ     = 50000,
  parameter int PAUSE_US    = 200,
  parameter int RET_MS      = 64,
  parameter int ROWS        = 4096,
  parameter int INIT_CYCLES = 8,
  parameter int PEND_MAX    = 8,
  parameter int T_CSR_NS    = 5,
  parameter int T_RAS_NS    = 60,
  parameter int T_RP_NS     = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_done
);
  localparam int PAUSE_CYC = us_to_cycles(PAUSE_US, CLK_KHZ);
  localparam int INT_CYC   = refresh_spacing(RET_MS, CLK_KHZ, ROWS);
  localparam int CSR_CYC   = ns_to_cycles(T_CSR_NS, CLK_KHZ);
  localparam int RAS_CYC   = ns_to_cycles(T_RAS_NS, CLK_KHZ);
  localparam int RP_CYC    = ns_to_cycles(T_RP_NS, CLK_KHZ);
  localparam int TOP_N     = (INIT_CYCLES > PEND_MAX) ? INIT_CYCLES : PEND_MAX;
  localparam int PCW       = $clog2(TOP_N + 1);
  localparam int LW        = $clog2(RAS_CYC + 2);

  logic           pause_done, pause_fire, interval_tick;
  logic           has_work, cyc_start, cyc_end;
  logic [PCW-1:0] pend_cnt;
  logic           done_q;
  logic [LW-1:0]  ras_lo_run;

  dram_ref_pace #(.PAUSE_CYC(PAUSE_CYC), .INT_CYC(INT_CYC)) u_pace (
    .clk(clk), .rst_n(rst_n), .run_en(done_q),
    .pause_done(pause_done), .pause_fire(pause_fire), .tick(interval_tick)
  );

  dram_ref_pend #(.INIT_N(INIT_CYCLES), .MAX_N(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .load(pause_fire), .due(interval_tick),
    .take(cyc_start), .has_work(has_work), .cnt(pend_cnt)
  );

  dram_ref_wave #(.CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_wave (
    .clk(clk), .rst_n(rst_n), .has_work(has_work), .gnt(ref_gnt),
    .cyc_start(cyc_start), .cyc_end(cyc_end), .ras_n(ras_n), .cas_n(cas_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else if (cyc_end && (pend_cnt == '0)) done_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ras_n) ras_lo_run <= '0;
    else                 ras_lo_run <= ras_lo_run + 1'b1;
  end

  assign ref_req   = has_work;
  assign init_done = done_q;
  assign we_n      = 1'b1;

  // R3
  init_done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R3
  init_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> pause_done);

  // R4
  start_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(ref_gnt));

  // R6
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_lo_run == LW'(RAS_CYC)));

  // R2
  quiet_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> (ras_n && cas_n && !ref_req));

endmodule

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
  localparam int PAUSE = 100;                 // ceil(50000*2/1000)
  localparam int INTV  = 195;                 // floor(50000*1/256)
  localparam int CSR   = 1;                   // ceil(5 ns at 20 ns)
  localparam int RASW  = 3;                   // ceil(60/20)
  localparam int RP    = 2;                   // ceil(40/20)
  localparam int BURST = 1 + CSR + RASW + RP; // back-to-back spacing

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ras_n, cas_n, we_n, init_done;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int ras_falls = 0;
  int last_fall = 0;
  int prev_fall = 0;
  int lo_run = 0;
  int hi_run = 0;
  int cas_run = 0;
  logic prev_ras = 1'b1;
  logic we_bad = 1'b0;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .CLK_KHZ(50000), .PAUSE_US(2), .RET_MS(1), .ROWS(256),
    .INIT_CYCLES(8), .PEND_MAX(8), .T_CSR_NS(5), .T_RAS_NS(60), .T_RP_NS(40)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // waveform monitor: R5, R6, R7
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (we_n !== 1'b1) we_bad = 1'b1;
      if (prev_ras && !ras_n) begin
        ras_falls++;
        prev_fall = last_fall;
        last_fall = cyc;
        chk(cas_run >= CSR, "R5 cas setup", cas_run, CSR);
        chk(hi_run >= RP, "R6 precharge", hi_run, RP);
        hi_run = 0;
      end
      if (!ras_n) begin
        lo_run++;
        if (cas_n) chk(1'b0, "R5 cas high while ras low", 1, 0);
      end
      if (!prev_ras && ras_n) begin
        chk(lo_run == RASW, "R6 ras width", lo_run, RASW);
        lo_run = 0;
      end
      if (ras_n) hi_run++;
      cas_run = cas_n ? 0 : cas_run + 1;
      prev_ras = ras_n;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk(ras_n == 1'b1, "R1 ras_n", ras_n, 1);
    chk(cas_n == 1'b1, "R1 cas_n", cas_n, 1);
    chk(we_n == 1'b1, "R1 we_n", we_n, 1);
    chk(ref_req == 1'b0, "R1 ref_req", ref_req, 0);
    chk(init_done == 1'b0, "R1 init_done", init_done, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_pause();
    int n = 0;
    logic busy = 1'b0;
    while (!ref_req && n < PAUSE + 20) begin
      @(negedge clk);
      n++;
      if (!ras_n || !cas_n) busy = 1'b1;
    end
    chk(n >= PAUSE && n <= PAUSE + 2, "R2 pause length", n, PAUSE);
    chk(!busy, "R2 strobes idle in pause", busy, 0);
  endtask

  task automatic t_init();
    int base;
    int n = 0;
    logic busy = 1'b0;
    logic early = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (!ras_n || !cas_n) busy = 1'b1;
    end
    chk(!busy, "R4 no cycle without grant", busy, 0);
    chk(ref_req == 1'b1, "R4 request held", ref_req, 1);
    base = ras_falls;
    ref_gnt = 1'b1;
    while (!init_done && n < 300) begin
      @(negedge clk);
      n++;
      if (init_done && (ras_falls - base) < 8) early = 1'b1;
    end
    chk(ras_falls - base == 8, "R3 init cycle count", ras_falls - base, 8);
    chk(!early, "R3 done not early", early, 0);
    chk(ras_n == 1'b1, "R3 ras high at done", ras_n, 1);
  endtask

  task automatic t_interval();
    for (int k = 0; k < 3; k++) begin
      int base = ras_falls;
      int n = 0;
      while (ras_falls == base && n < 2 * INTV) begin
        @(negedge clk);
        n++;
      end
      if (k > 0) chk(last_fall - prev_fall == INTV, "R8 spacing", last_fall - prev_fall, INTV);
    end
    repeat (RASW + 2) @(negedge clk);
    chk(ref_req == 1'b0, "R9 req drops when serviced", ref_req, 0);
    chk(init_done == 1'b1, "R3 done sticky", init_done, 1);
  endtask

  task automatic t_backlog(input int due_n, input int expect_n, input string tag);
    int base;
    int n = 0;
    ref_gnt = 1'b0;
    while (!ref_req && n < 2 * INTV) begin
      @(negedge clk);
      n++;
    end
    base = ras_falls;
    repeat ((due_n - 1) * INTV + INTV / 2) @(negedge clk);
    chk(ras_falls == base, "R4 held off without grant", ras_falls - base, 0);
    chk(ref_req == 1'b1, "R9 req while pending", ref_req, 1);
    ref_gnt = 1'b1;
    repeat (80) @(negedge clk);
    ref_gnt = 1'b0;
    chk(ras_falls - base == expect_n, tag, ras_falls - base, expect_n);
    chk(last_fall - prev_fall == BURST, "R9 back-to-back", last_fall - prev_fall, BURST);
    chk(ref_req == 1'b0, "R9 req cleared", ref_req, 0);
  endtask

  initial begin
    t_reset();
    t_pause();
    t_init();
    t_interval();
    t_backlog(5, 5, "R9 backlog count");
    t_backlog(12, 8, "R10 backlog ceiling");
    chk(!we_bad, "R7 we_n high", we_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule